// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider setting of one phase-locked loop without ever handing a glitching or unlocked clock to the logic downstream. A single-cycle start pulse carries three raw divider values. These are the reference pre-divider, the feedback multiplier and the post-divider. The block first checks that the request gives a legal oscillator frequency. It then moves the PLL output selection onto the reference oscillator. Next it holds the PLL in reset, writes the register-ready divider fields and waits a settle time before it releases reset. Finally it waits for the lock input and switches the output back to the PLL.

An illegal request is refused at once. The refusal is a one-cycle error pulse, and no output moves. If lock never comes, a timeout ends the attempt with an error pulse and leaves the clock on the reference. The analog PLL is not part of the block. Its lock flag arrives on an input.

Top module: `pll_reprog_seq`

## Requirements
- R1: After synchronous reset, `mode_slow`=1, `pll_rst`=0, all four field outputs are 0, and `busy`, `done` and `err` are 0.
- R2: A request is legal only under all of these conditions: 1 ≤ nr ≤ 64, 1 ≤ nf ≤ 8192, and 1 ≤ no ≤ 16 with no equal to 1 or even. REF_KHZ·nf/nr must lie within 440000..2200000 kHz inclusive, and (REF_KHZ·nf/nr)/no must be at least 27500 kHz.
- R3: A start in idle with an illegal request gives `err`=1 in the next cycle. `busy` stays 0, and `mode_slow`, `pll_rst` and the fields keep their values.
- R4: A legal start sets `mode_slow`=1 first. `pll_rst` rises one cycle later and is never 1 while `mode_slow` is 0.
- R5: The fields are encoded as follows: `fld_nr`=nr-1 (6 bits), `fld_nf`=nf-1 (13 bits), `fld_no`=no-1 (4 bits) and `fld_bw`=(nf>>1)-1 (12 bits). They change only while `pll_rst` is held, and they persist after the sequence ends.
- R6: `pll_rst` stays 1 for exactly SETTLE_CYC+1 cycles, where SETTLE_CYC = CLK_MHZ·SETTLE_US. That is one cycle for programming and SETTLE_CYC cycles of settling.
- R7: `pll_lock` is ignored until `pll_rst` has fallen. The first sampled lock after that clears `mode_slow` in the same cycle as the `done` pulse.
- R8: If lock is absent for LOCK_TMO cycles after `pll_rst` falls, `err` pulses exactly LOCK_TMO cycles after the fall. In that case `mode_slow` stays 1 and `pll_rst` stays 0.
- R9: A start while `busy`=1 is ignored. The running request completes with its own fields.
- R10: `done` and `err` are single-cycle pulses and are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| req_nr | input | 7 | Reference pre-divider, raw value |
| req_nf | input | 14 | Feedback multiplier, raw value |
| req_no | input | 5 | Post-divider, raw value |
| pll_lock | input | 1 | Lock flag from the PLL |
| fld_nr | output | 6 | Pre-divider field (nr-1) |
| fld_nf | output | 13 | Multiplier field (nf-1) |
| fld_no | output | 4 | Post-divider field (no-1) |
| fld_bw | output | 12 | Loop bandwidth field ((nf>>1)-1) |
| pll_rst | output | 1 | PLL reset control |
| mode_slow | output | 1 | 1 selects reference oscillator, 0 selects PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Pulse: reprogramming completed in normal mode |
| err | output | 1 | Pulse: request refused or lock timed out |

## Verification
The bench exercises the exact legality boundaries. These are a 440000 kHz oscillator with a 27500 kHz output, and an oscillator one multiplier step above 2200000 kHz. It also sends an odd post-divider, a zero pre-divider, a lock flag left high from a previous run while reset is held, a lock that never comes, and a second start during a run. A design that misplaced a boundary would either refuse a legal setting or program an illegal one. A design that did not gate lock would leave reset early or switch to normal mode on a stale flag. Forgetting to ignore the intruding start would overwrite the fields in mid-sequence. Any of these shows up as a mismatch against the scoreboard, or as a wrong count of reset or lock-wait cycles.

// File: rtl/pll_seq_pkg.sv
// Package: shared state encoding and fixed frequency limits (kHz) for the
// PLL reprogramming sequencer. Assumes all rates are expressed in kHz.
package pll_seq_pkg;
    localparam longint VCO_MIN_KHZ = 440000;
    localparam longint VCO_MAX_KHZ = 2200000;
    localparam longint OUT_MIN_KHZ = 27500;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST,
        S_PROG,
        S_SETTLE,
        S_LOCK
    } seq_state_t;
endpackage

// File: rtl/pll_req_check.sv
// Module: combinational legality test of a raw divider request.
// Assumes REF_KHZ is the reference frequency; no division is used, all
// range limits are compared through cross-multiplication.
module pll_req_check #(
    parameter int NR_W    = 6,
    parameter int NF_W    = 13,
    parameter int NO_W    = 4,
    parameter int REF_KHZ = 24000
) (
    input  logic [NR_W:0] req_nr,
    input  logic [NF_W:0] req_nf,
    input  logic [NO_W:0] req_no,
    output logic          legal
);
    import pll_seq_pkg::*;

    localparam int NR_MAX = 1 << NR_W;
    localparam int NF_MAX = 1 << NF_W;
    localparam int NO_MAX = 1 << NO_W;

    logic [63:0] ref_nf, lo_lim, hi_lim, out_lim;
    logic        range_ok, parity_ok;

    // Cross-multiplied VCO and output-frequency limits.
    always_comb begin
        ref_nf    = 64'(REF_KHZ) * 64'(req_nf);
        lo_lim    = 64'(VCO_MIN_KHZ) * 64'(req_nr);
        hi_lim    = 64'(VCO_MAX_KHZ) * 64'(req_nr);
        out_lim   = 64'(OUT_MIN_KHZ) * 64'(req_nr) * 64'(req_no);
        range_ok  = (req_nr != '0) && (req_nf != '0) && (req_no != '0)
                 && (req_nr <= (NR_W+1)'(NR_MAX))
                 && (req_nf <= (NF_W+1)'(NF_MAX))
                 && (req_no <= (NO_W+1)'(NO_MAX));
        parity_ok = (req_no == (NO_W+1)'(1)) || !req_no[0];
        legal     = range_ok && parity_ok
                 && (ref_nf >= lo_lim) && (ref_nf <= hi_lim)
                 && (ref_nf >= out_lim);
    end
endmodule

// File: rtl/pll_field_enc.sv
// Module: maps raw divider values to register fields (value minus one) and
// derives the loop bandwidth field from the multiplier.
// Assumes the request was already found legal (all values >= 1).
module pll_field_enc #(
    parameter int NR_W = 6,
    parameter int NF_W = 13,
    parameter int NO_W = 4,
    parameter int BW_W = 12
) (
    input  logic [NR_W:0]   raw_nr,
    input  logic [NF_W:0]   raw_nf,
    input  logic [NO_W:0]   raw_no,
    output logic [NR_W-1:0] enc_nr,
    output logic [NF_W-1:0] enc_nf,
    output logic [NO_W-1:0] enc_no,
    output logic [BW_W-1:0] enc_bw
);
    logic [NR_W:0] m_nr;
    logic [NF_W:0] m_nf, m_bw;
    logic [NO_W:0] m_no;

    // Minus-one encoding with explicit truncation to field width.
    always_comb begin
        m_nr   = raw_nr - (NR_W+1)'(1);
        m_nf   = raw_nf - (NF_W+1)'(1);
        m_no   = raw_no - (NO_W+1)'(1);
        m_bw   = (raw_nf >> 1) - (NF_W+1)'(1);
        enc_nr = m_nr[NR_W-1:0];
        enc_nf = m_nf[NF_W-1:0];
        enc_no = m_no[NO_W-1:0];
        enc_bw = m_bw[BW_W-1:0];
    end
endmodule

// File: rtl/pll_wait_timer.sv
// Module: loadable down-counter shared by the settle and lock-wait phases.
// Assumes load values fit in CNT_W bits; zero reports an elapsed window.
module pll_wait_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pll_reprog_seq.sv
// Module: top of the PLL reprogramming sequencer. It walks the fixed order
// slow mode -> reset -> program -> settle -> release -> lock wait -> normal.
// Assumes one PLL, a synchronous lock flag and SETTLE_CYC >= 1.
module pll_reprog_seq #(
    parameter int NR_W      = 6,
    parameter int NF_W      = 13,
    parameter int NO_W      = 4,
    parameter int BW_W      = 12,
    parameter int REF_KHZ   = 24000,
    parameter int CLK_MHZ   = 100,
    parameter int SETTLE_US = 10,
    parameter int LOCK_TMO  = 4000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NR_W:0]   req_nr,
    input  logic [NF_W:0]   req_nf,
    input  logic [NO_W:0]   req_no,
    input  logic            pll_lock,
    output logic [NR_W-1:0] fld_nr,
    output logic [NF_W-1:0] fld_nf,
    output logic [NO_W-1:0] fld_no,
    output logic [BW_W-1:0] fld_bw,
    output logic            pll_rst,
    output logic            mode_slow,
    output logic            busy,
    output logic            done,
    output logic            err
);
    import pll_seq_pkg::*;

    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int MAX_WAIT   = (SETTLE_CYC > LOCK_TMO) ? SETTLE_CYC : LOCK_TMO;
    localparam int CNT_W      = $clog2(MAX_WAIT + 1);

    seq_state_t      state;
    logic [NR_W:0]   q_nr;
    logic [NF_W:0]   q_nf;
    logic [NO_W:0]   q_no;
    logic            req_legal, tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic [NR_W-1:0] e_nr;
    logic [NF_W-1:0] e_nf;
    logic [NO_W-1:0] e_no;
    logic [BW_W-1:0] e_bw;

    pll_req_check #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .REF_KHZ(REF_KHZ)) u_chk (
        .req_nr(req_nr), .req_nf(req_nf), .req_no(req_no), .legal(req_legal)
    );

    pll_field_enc #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W)) u_enc (
        .raw_nr(q_nr), .raw_nf(q_nf), .raw_no(q_no),
        .enc_nr(e_nr), .enc_nf(e_nf), .enc_no(e_no), .enc_bw(e_bw)
    );

    // Timer reload: settle window on programming, lock window on release.
    always_comb begin
        tmr_load = (state == S_PROG) || ((state == S_SETTLE) && tmr_zero);
        tmr_val  = (state == S_PROG) ? CNT_W'(SETTLE_CYC - 1) : CNT_W'(LOCK_TMO - 1);
    end

    pll_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    // Sequencer: owns mode, reset, fields and the result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            mode_slow <= 1'b1;
            pll_rst   <= 1'b0;
            fld_nr    <= '0;
            fld_nf    <= '0;
            fld_no    <= '0;
            fld_bw    <= '0;
            q_nr      <= '0;
            q_nf      <= '0;
            q_no      <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    if (!req_legal) begin
                        err <= 1'b1;
                    end else begin
                        mode_slow <= 1'b1;
                        q_nr      <= req_nr;
                        q_nf      <= req_nf;
                        q_no      <= req_no;
                        state     <= S_RST;
                    end
                end
                S_RST: begin
                    pll_rst <= 1'b1;
                    state   <= S_PROG;
                end
                S_PROG: begin
                    fld_nr <= e_nr;
                    fld_nf <= e_nf;
                    fld_no <= e_no;
                    fld_bw <= e_bw;
                    state  <= S_SETTLE;
                end
                S_SETTLE: if (tmr_zero) begin
                    pll_rst <= 1'b0;
                    state   <= S_LOCK;
                end
                S_LOCK: begin
                    if (pll_lock) begin
                        mode_slow <= 1'b0;
                        done      <= 1'b1;
                        state     <= S_IDLE;
                    end else if (tmr_zero) begin
                        err   <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy = (state != S_IDLE);

    // Reset may only be driven while the reference clock is selected.
    assert_rst_only_slow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> mode_slow);

    // Leaving slow mode requires a lock sample in the previous cycle.
    assert_normal_after_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_slow) |-> $past(pll_lock));

    // Divider fields move only while reset has been held.
    assert_fields_under_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fld_nf) || !$stable(fld_nr) || !$stable(fld_no) || !$stable(fld_bw))
        |-> (pll_rst && $past(pll_rst)));

    // Result pulses are exclusive.
    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // A refused request never starts a sequence.
    assert_illegal_no_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !$past(busy)) |-> !busy);

    // A timeout leaves the clock on the reference oscillator.
    assert_timeout_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && $past(busy)) |-> (mode_slow && !pll_rst));
endmodule

// File: tb/sim_pll_reprog_seq.sv
// Bench: scoreboard. The driver pushes expected results; the monitor pops and
// compares on each done/err pulse. A lock model answers the released PLL.
module sim_pll_reprog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 2;
    localparam int SETTLE_US  = 10;
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int LOCK_TMO   = 40;
    localparam int REF_KHZ    = 24000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  req_nr = '0;
    logic [13:0] req_nf = '0;
    logic [4:0]  req_no = '0;
    logic        pll_lock = 1'b0;
    logic [5:0]  fld_nr;
    logic [12:0] fld_nf;
    logic [3:0]  fld_no;
    logic [11:0] fld_bw;
    logic        pll_rst, mode_slow, busy, done, err;

    pll_reprog_seq #(.REF_KHZ(REF_KHZ), .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US),
                     .LOCK_TMO(LOCK_TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .req_nr(req_nr), .req_nf(req_nf),
        .req_no(req_no), .pll_lock(pll_lock), .fld_nr(fld_nr), .fld_nf(fld_nf),
        .fld_no(fld_no), .fld_bw(fld_bw), .pll_rst(pll_rst), .mode_slow(mode_slow),
        .busy(busy), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit         is_err;
        bit         timeout;
        bit         slow;
        logic [5:0] nr;
        logic [12:0] nf;
        logic [3:0] no;
        logic [11:0] bw;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0, n_errs = 0, n_seen = 0, n_issued = 0;
    int   lock_lat = 3;
    bit   lock_never = 0, lock_stale = 0;
    int   lk_cnt = 0, rst_len = 0, rel_cnt = 0;
    logic [5:0] m_nr = '0;
    logic [12:0] m_nf = '0;
    logic [3:0] m_no = '0;
    logic [11:0] m_bw = '0;
    bit   m_slow = 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit legal_req(input int nr, input int nf, input int no);
        longint v;
        if (nr < 1 || nr > 64 || nf < 1 || nf > 8192 || no < 1 || no > 16) return 0;
        if (no != 1 && (no % 2) != 0) return 0;
        if (longint'(REF_KHZ) * nf < longint'(440000) * nr) return 0;
        if (longint'(REF_KHZ) * nf > longint'(2200000) * nr) return 0;
        v = longint'(REF_KHZ) * nf;
        if (v < longint'(27500) * nr * no) return 0;
        return 1;
    endfunction

    // Lock model: low (or stale) under reset, rises lock_lat cycles after release.
    always @(negedge clk) begin
        if (pll_rst) begin
            pll_lock <= lock_stale;
            lk_cnt   <= 0;
        end else if (busy) begin
            if (lock_never) pll_lock <= 1'b0;
            else if (lk_cnt >= lock_lat) pll_lock <= 1'b1;
            else begin
                pll_lock <= 1'b0;
                lk_cnt   <= lk_cnt + 1;
            end
        end
    end

    // Monitor: reset window length, lock-wait length, and scoreboard pops.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pll_rst) begin
                rst_len++;
                rel_cnt = 0;
                if (!mode_slow) chk(0, "R4 reset while normal", 0, 1);
            end else begin
                if (rst_len != 0) chk(rst_len == SETTLE_CYC + 1, "R6 reset length", rst_len, SETTLE_CYC + 1);
                rst_len = 0;
                if (busy && u_dummy_ok()) rel_cnt++;
            end
            if (done || err) begin
                exp_t e;
                n_seen++;
                chk(!(done && err), "R10 exclusive flags", done, 0);
                if (exp_q.size() == 0) chk(0, "R9 unexpected result", 1, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(err == e.is_err, "R3/R7 result kind", err, e.is_err);
                    chk(mode_slow == e.slow, "R7/R8 mode select", mode_slow, e.slow);
                    chk(pll_rst == 1'b0, "R8 reset released", pll_rst, 0);
                    chk(fld_nr == e.nr, "R5 nr field", fld_nr, e.nr);
                    chk(fld_nf == e.nf, "R5 nf field", fld_nf, e.nf);
                    chk(fld_no == e.no, "R5 no field", fld_no, e.no);
                    chk(fld_bw == e.bw, "R5 bw field", fld_bw, e.bw);
                    if (e.timeout) chk(rel_cnt == LOCK_TMO, "R8 timeout length", rel_cnt, LOCK_TMO);
                end
            end
            if (done || err) rel_cnt = 0;
        end
    end

    function automatic bit u_dummy_ok();
        return 1'b1;
    endfunction

    // Driver: predict the outcome, push it, pulse start, wait for the result.
    task automatic run_req(input int nr, input int nf, input int no, input int lat,
                           input bit never, input bit stale, input bit intrude);
        exp_t e;
        bit ok;
        ok = legal_req(nr, nf, no);
        lock_lat = lat; lock_never = never; lock_stale = stale;
        if (ok) begin
            m_nr = 6'(nr - 1); m_nf = 13'(nf - 1); m_no = 4'(no - 1);
            m_bw = 12'((nf >> 1) - 1);
            m_slow = never;
        end
        e.is_err = !ok || never; e.timeout = ok && never; e.slow = m_slow;
        e.nr = m_nr; e.nf = m_nf; e.no = m_no; e.bw = m_bw;
        exp_q.push_back(e);
        n_issued++;
        @(negedge clk);
        req_nr = 7'(nr); req_nf = 14'(nf); req_no = 5'(no); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!ok) chk(busy == 1'b0, "R3 no busy on refusal", busy, 0);
        else     chk(busy == 1'b1 && mode_slow == 1'b1 && pll_rst == 1'b0, "R4 slow before reset", pll_rst, 0);
        if (intrude) begin
            repeat (4) @(negedge clk);
            req_nr = 7'd2; req_nf = 14'd99; req_no = 5'd2; start = 1'b1;   // R9
            @(negedge clk);
            start = 1'b0;
        end
        while (n_seen < n_issued) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0 && err == 1'b0, "R10 pulse width", done | err, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mode_slow == 1'b1, "R1 mode", mode_slow, 1);
        chk(pll_rst == 1'b0, "R1 reset", pll_rst, 0);
        chk({fld_nr, fld_nf, fld_no, fld_bw} == '0, "R1 fields", fld_nf, 0);
        chk({busy, done, err} == 3'b000, "R1 flags", {busy, done, err}, 0);
        run_req(1, 75, 1, 3, 0, 0, 0);     // R2 plain legal, R7 lock
        run_req(1, 75, 3, 3, 0, 0, 0);     // R2/R3 odd post-divider
        run_req(2, 99, 2, 0, 0, 0, 0);     // legal, lock immediately after release
        run_req(3, 55, 16, 5, 0, 0, 0);    // R2 exact lower VCO and output bound
        run_req(1, 18, 1, 3, 0, 0, 0);     // R2 VCO below range
        run_req(1, 92, 1, 3, 0, 0, 0);     // R2 VCO above range
        run_req(1, 91, 1, 3, 0, 0, 0);     // R2 highest legal step
        run_req(0, 75, 1, 3, 0, 0, 0);     // R2 zero pre-divider
        run_req(9, 400, 2, 6, 0, 1, 0);    // R7 stale lock during reset ignored
        run_req(1, 75, 2, 4, 0, 0, 1);     // R9 intruding start ignored
        run_req(1, 80, 2, 0, 1, 0, 0);     // R8 lock timeout
        run_req(1, 75, 5, 3, 0, 0, 0);     // R3 refusal after timeout keeps slow mode
        run_req(1, 75, 1, 2, 0, 0, 0);     // recovery after timeout
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule